// File: doc/BRIEF.md
# Password Retry Lockout Controller

This block stands between a password comparator and a small protected memory. Each time the comparator finishes checking an attempt, it presents a one-cycle pulse together with a flag that says whether the attempt matched. The block keeps a count of consecutive failed attempts. It grants access on a match, and it keeps access granted until the surrounding logic signals the end of the session.

A run of failures is tolerated up to a fixed limit. The next failure after that limit starts a destructive wipe. The block drives a clear port that writes zero into every word of the protected memory, one word per cycle. It then writes zero into each of the two stored password registers. After that it resets its failure count and returns to normal service.

Attempts that arrive while the wipe is running are discarded. A synchronous reset returns the control state to idle and leaves the stored contents alone.

Top module: `pwd_lockout_ctrl`

## Requirements
- R1: While `rst` is high, the next clock edge sets `fail_count` to 0 and drops `access_granted`, `wipe_busy`, `wipe_mem_we` and `wipe_pwd_we`. Reset issues no clear write, so the memory and password contents are not changed.
- R2: An attempt taken while `wipe_busy` is low, with `cmp_done`=1 and `cmp_match`=0, raises `fail_count` by one in the next cycle. This holds whichever password was being tried.
- R3: Eight consecutive failed attempts leave `fail_count` at 8 and `wipe_busy` low. No clear write is issued.
- R4: A failed attempt taken while `fail_count` is 8 starts the wipe. In the next cycle `wipe_busy`=1, `fail_count`=9 and `access_granted`=0, and the first memory clear is issued with `wipe_mem_we`=1 and `wipe_mem_addr`=0.
- R5: The memory clears run for MEM_DEPTH consecutive cycles, starting in the first cycle of the wipe. The address rises by one each cycle, from 0 to MEM_DEPTH-1, with one write per cycle.
- R6: In the two cycles that follow the last memory clear, `wipe_pwd_we`=1 with `wipe_pwd_idx`=0 and then 1. `wipe_mem_we` is never high in the same cycle as `wipe_pwd_we`.
- R7: `wipe_busy` stays high for exactly MEM_DEPTH+2 cycles. In the cycle after the last password clear, it is low and `fail_count` is 0.
- R8: While `wipe_busy` is high, `cmp_done` pulses are ignored. They neither count nor grant access.
- R9: A matching attempt taken while `wipe_busy` is low sets `fail_count` to 0 and `access_granted` to 1 in the next cycle.
- R10: `access_granted` stays high until a `session_end` pulse clears it in the next cycle. If a matching attempt lands in the same cycle as `session_end`, access stays granted.
- R11: After a wipe, every memory word and both password registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_done | input | 1 | One-cycle pulse: a password comparison has finished |
| cmp_match | input | 1 | Comparison result, valid with cmp_done (1 = match) |
| session_end | input | 1 | Pulse that ends the granted session |
| access_granted | output | 1 | Access is currently granted |
| wipe_busy | output | 1 | Wipe sequence in progress |
| fail_count | output | CNT_W | Consecutive failed attempts |
| wipe_mem_we | output | 1 | Write zero to memory word at wipe_mem_addr |
| wipe_mem_addr | output | $clog2(MEM_DEPTH) | Memory word being cleared |
| wipe_pwd_we | output | 1 | Write zero to password register wipe_pwd_idx |
| wipe_pwd_idx | output | 1 | Password register being cleared |

## Verification
There are two coincidences to check. The first is a matching attempt in the same cycle as a `session_end` pulse. The bench drives both in one cycle and expects `access_granted` to stay high, because the new grant takes priority over the revoke. The second is an attempt arriving in any cycle of the wipe, including its last one. The randomized runs produce this often, since their match rate is low. A cycle-accurate reference model judges each case: it expects the count to be unchanged or cleared and no grant to appear.

// File: rtl/lockout_pkg.sv
package lockout_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_MEM  = 2'd1,
    WS_PWD  = 2'd2
  } wipe_state_t;

endpackage

// File: rtl/lockout_fail_counter.sv
module lockout_fail_counter #(
  parameter int CNT_W      = 4,
  parameter int FAIL_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail_pulse,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(FAIL_LIMIT);
  localparam logic [CNT_W-1:0] SAT_V   = {CNT_W{1'b1}};

  // Overflow is the failure that arrives with the count already at the limit.
  assign overflow = fail_pulse && (count == LIMIT_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (fail_pulse && (count != SAT_V)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/lockout_wipe_seq.sv
module lockout_wipe_seq
  import lockout_pkg::*;
#(
  parameter int  MEM_DEPTH = 16,
  parameter int  NUM_PWD   = 2,
  localparam int ADDR_W    = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
  localparam int PIDX_W    = (NUM_PWD > 1) ? $clog2(NUM_PWD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              finish,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              pwd_we,
  output logic [PIDX_W-1:0] pwd_idx
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_DEPTH - 1);
  localparam logic [PIDX_W-1:0] LAST_PWD  = PIDX_W'(NUM_PWD - 1);

  wipe_state_t state;

  // Last cycle of the sequence: the final password register is being cleared.
  assign finish = (state == WS_PWD) && (pwd_idx == LAST_PWD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WS_IDLE;
      busy     <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      pwd_we   <= 1'b0;
      pwd_idx  <= '0;
    end else begin
      unique case (state)
        WS_IDLE: begin
          if (start) begin
            state    <= WS_MEM;
            busy     <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= '0;
          end
        end
        WS_MEM: begin
          if (mem_addr == LAST_ADDR) begin
            state   <= WS_PWD;
            mem_we  <= 1'b0;
            pwd_we  <= 1'b1;
            pwd_idx <= '0;
          end else begin
            mem_addr <= mem_addr + 1'b1;
          end
        end
        WS_PWD: begin
          if (pwd_idx == LAST_PWD) begin
            state  <= WS_IDLE;
            pwd_we <= 1'b0;
            busy   <= 1'b0;
          end else begin
            pwd_idx <= pwd_idx + 1'b1;
          end
        end
        default: begin
          state  <= WS_IDLE;
          busy   <= 1'b0;
          mem_we <= 1'b0;
          pwd_we <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lockout_access_latch.sv
module lockout_access_latch (
  input  logic clk,
  input  logic rst,
  input  logic grant_set,
  input  logic revoke,
  output logic granted
);

  // A new grant takes priority over a revoke in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      granted <= 1'b0;
    end else if (grant_set) begin
      granted <= 1'b1;
    end else if (revoke) begin
      granted <= 1'b0;
    end
  end

endmodule

// File: rtl/pwd_lockout_ctrl.sv
module pwd_lockout_ctrl #(
  parameter int  MEM_DEPTH  = 16,
  parameter int  CNT_W      = 4,
  parameter int  FAIL_LIMIT = 8,
  localparam int ADDR_W     = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_done,
  input  logic              cmp_match,
  input  logic              session_end,
  output logic              access_granted,
  output logic              wipe_busy,
  output logic [CNT_W-1:0]  fail_count,
  output logic              wipe_mem_we,
  output logic [ADDR_W-1:0] wipe_mem_addr,
  output logic              wipe_pwd_we,
  output logic [0:0]        wipe_pwd_idx
);

  localparam int NUM_PWD = 2;

  logic attempt_ok;
  logic match_hit;
  logic fail_hit;
  logic overflow;
  logic wipe_finish;

  // Attempts are accepted only outside the wipe.
  assign attempt_ok = cmp_done && !wipe_busy;
  assign match_hit  = attempt_ok && cmp_match;
  assign fail_hit   = attempt_ok && !cmp_match;

  lockout_fail_counter #(
    .CNT_W      (CNT_W),
    .FAIL_LIMIT (FAIL_LIMIT)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .fail_pulse (fail_hit),
    .clear      (match_hit || wipe_finish),
    .count      (fail_count),
    .overflow   (overflow)
  );

  lockout_wipe_seq #(
    .MEM_DEPTH (MEM_DEPTH),
    .NUM_PWD   (NUM_PWD)
  ) u_wipe (
    .clk      (clk),
    .rst      (rst),
    .start    (overflow),
    .busy     (wipe_busy),
    .finish   (wipe_finish),
    .mem_we   (wipe_mem_we),
    .mem_addr (wipe_mem_addr),
    .pwd_we   (wipe_pwd_we),
    .pwd_idx  (wipe_pwd_idx)
  );

  lockout_access_latch u_acc (
    .clk       (clk),
    .rst       (rst),
    .grant_set (match_hit),
    .revoke    (session_end || overflow),
    .granted   (access_granted)
  );

endmodule

// File: rtl/lockout_checker.sv
module lockout_checker #(
  parameter int MEM_DEPTH  = 16,
  parameter int CNT_W      = 4,
  parameter int FAIL_LIMIT = 8,
  parameter int ADDR_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_done,
  input logic              cmp_match,
  input logic              session_end,
  input logic              access_granted,
  input logic              wipe_busy,
  input logic [CNT_W-1:0]  fail_count,
  input logic              wipe_mem_we,
  input logic [ADDR_W-1:0] wipe_mem_addr,
  input logic              wipe_pwd_we,
  input logic [0:0]        wipe_pwd_idx
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (fail_count == '0) && !access_granted && !wipe_busy && !wipe_mem_we && !wipe_pwd_we);

  a_r2_fail_steps: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && !cmp_match && !wipe_busy && (int'(fail_count) < FAIL_LIMIT))
      |=> (int'(fail_count) == int'($past(fail_count)) + 1));

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(fail_count) <= FAIL_LIMIT + 1);

  a_r4_overflow_wipes: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && !cmp_match && !wipe_busy && (int'(fail_count) == FAIL_LIMIT))
      |=> wipe_busy && wipe_mem_we && (wipe_mem_addr == '0) && !access_granted);

  a_r5_addr_walk: assert property (@(posedge clk) disable iff (rst)
    (wipe_mem_we && $past(wipe_mem_we))
      |-> (int'(wipe_mem_addr) == int'($past(wipe_mem_addr)) + 1));

  a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
    !(wipe_mem_we && wipe_pwd_we));

  a_r6_clear_in_wipe: assert property (@(posedge clk) disable iff (rst)
    (wipe_mem_we || wipe_pwd_we) |-> wipe_busy);

  a_r8_busy_holds_count: assert property (@(posedge clk) disable iff (rst)
    wipe_busy |=> ($stable(fail_count) || (fail_count == '0)));

  a_r8_busy_no_grant: assert property (@(posedge clk) disable iff (rst)
    (wipe_busy && !access_granted) |=> !access_granted);

  a_r9_match_grants: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && cmp_match && !wipe_busy) |=> access_granted && (fail_count == '0));

  a_r10_session_close: assert property (@(posedge clk) disable iff (rst)
    (session_end && !(cmp_done && cmp_match && !wipe_busy)) |=> !access_granted);

endmodule

bind pwd_lockout_ctrl lockout_checker #(
  .MEM_DEPTH  (MEM_DEPTH),
  .CNT_W      (CNT_W),
  .FAIL_LIMIT (FAIL_LIMIT),
  .ADDR_W     (ADDR_W)
) u_lockout_chk (
  .clk            (clk),
  .rst            (rst),
  .cmp_done       (cmp_done),
  .cmp_match      (cmp_match),
  .session_end    (session_end),
  .access_granted (access_granted),
  .wipe_busy      (wipe_busy),
  .fail_count     (fail_count),
  .wipe_mem_we    (wipe_mem_we),
  .wipe_mem_addr  (wipe_mem_addr),
  .wipe_pwd_we    (wipe_pwd_we),
  .wipe_pwd_idx   (wipe_pwd_idx)
);

// File: tb/tb_pwd_lockout_ctrl.sv
`timescale 1ns/1ps
module tb_pwd_lockout_ctrl;

  localparam int D      = 16;
  localparam int CW     = 4;
  localparam int LIM    = 8;
  localparam int AW     = $clog2(D);

  logic          clk = 1'b0;
  logic          rst;
  logic          cmp_done;
  logic          cmp_match;
  logic          session_end;
  logic          access_granted;
  logic          wipe_busy;
  logic [CW-1:0] fail_count;
  logic          wipe_mem_we;
  logic [AW-1:0] wipe_mem_addr;
  logic          wipe_pwd_we;
  logic [0:0]    wipe_pwd_idx;

  always #10 clk = ~clk;

  pwd_lockout_ctrl #(.MEM_DEPTH(D), .CNT_W(CW), .FAIL_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .cmp_done(cmp_done), .cmp_match(cmp_match),
    .session_end(session_end), .access_granted(access_granted),
    .wipe_busy(wipe_busy), .fail_count(fail_count),
    .wipe_mem_we(wipe_mem_we), .wipe_mem_addr(wipe_mem_addr),
    .wipe_pwd_we(wipe_pwd_we), .wipe_pwd_idx(wipe_pwd_idx)
  );

  // Storage wrapper: clear port writes zero.
  logic [7:0]  mem [D];
  logic [31:0] pwd [2];
  always @(posedge clk) begin
    if (wipe_mem_we) mem[wipe_mem_addr] <= 8'h00;
    if (wipe_pwd_we) pwd[wipe_pwd_idx]  <= 32'h0;
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model state
  int m_cnt;
  bit m_grant;
  bit m_busy;
  int m_k;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void predict(bit d, bit m, bit s, bit r);
    if (r) begin
      m_cnt = 0; m_grant = 0; m_busy = 0; m_k = 0;
    end else if (m_busy) begin
      if (m_k == D + 1) begin m_busy = 0; m_cnt = 0; m_k = 0; end
      else m_k++;
      if (s) m_grant = 0;
    end else if (d && m) begin
      m_cnt = 0; m_grant = 1;
    end else begin
      if (d) begin
        if (m_cnt == LIM) begin m_busy = 1; m_k = 0; m_cnt = LIM + 1; m_grant = 0; end
        else m_cnt++;
      end
      if (s) m_grant = 0;
    end
  endfunction

  function automatic bit exp_mem_we();
    return m_busy && (m_k < D);
  endfunction

  function automatic bit exp_pwd_we();
    return m_busy && (m_k >= D);
  endfunction

  task automatic compare_all();
    check("R2 fail_count", int'(fail_count), m_cnt);
    check("R9 access_granted", int'(access_granted), int'(m_grant));
    check("R7 wipe_busy", int'(wipe_busy), int'(m_busy));
    check("R5 wipe_mem_we", int'(wipe_mem_we), int'(exp_mem_we()));
    if (exp_mem_we()) check("R5 wipe_mem_addr", int'(wipe_mem_addr), m_k);
    check("R6 wipe_pwd_we", int'(wipe_pwd_we), int'(exp_pwd_we()));
    if (exp_pwd_we()) check("R6 wipe_pwd_idx", int'(wipe_pwd_idx), m_k - D);
  endtask

  // Drive at a falling edge, predict, then compare at the next falling edge.
  task automatic step(bit d, bit m, bit s, bit r);
    cmp_done = d; cmp_match = m; session_end = s; rst = r;
    predict(d, m, s, r);
    @(negedge clk);
    compare_all();
  endtask

  task automatic fill_storage();
    for (int i = 0; i < D; i++) mem[i] = 8'h80 | 8'(i);
    pwd[0] = 32'hA5A5_0001;
    pwd[1] = 32'h5A5A_0002;
  endtask

  function automatic int nonzero_words();
    int n = 0;
    for (int i = 0; i < D; i++) if (mem[i] != 0) n++;
    for (int i = 0; i < 2; i++) if (pwd[i] != 0) n++;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0BAD_5EED));
    fill_storage();
    cmp_done = 0; cmp_match = 0; session_end = 0; rst = 1;
    m_cnt = 0; m_grant = 0; m_busy = 0; m_k = 0;
    @(negedge clk);
    step(0, 0, 0, 1);
    // R1: reset state, storage untouched
    check("R1 reset count", int'(fail_count), 0);
    check("R1 reset busy", int'(wipe_busy), 0);
    check("R1 storage kept", nonzero_words(), D + 2);

    // R3: eight failures tolerated
    for (int i = 0; i < LIM; i++) begin
      step(1, 0, 0, 0);
      step(0, 0, 0, 0);
    end
    check("R3 count at limit", int'(fail_count), LIM);
    check("R3 no wipe", int'(wipe_busy), 0);
    check("R3 storage intact", nonzero_words(), D + 2);

    // R4: ninth failure starts the wipe
    step(1, 0, 0, 0);
    check("R4 busy", int'(wipe_busy), 1);
    check("R4 count", int'(fail_count), LIM + 1);
    check("R4 first addr", int'(wipe_mem_addr), 0);

    // R8: attempts during the wipe (matches included) ignored
    for (int i = 0; i < D + 1; i++) step(1, (i % 2) == 0, 0, 0);
    check("R8 no grant during wipe", int'(access_granted), 0);
    check("R8 count frozen", int'(fail_count), LIM + 1);
    step(0, 0, 0, 0);
    // R7: wipe over
    check("R7 busy dropped", int'(wipe_busy), 0);
    check("R7 count cleared", int'(fail_count), 0);
    @(posedge clk); #1;
    check("R11 all words zero", nonzero_words(), 0);
    @(negedge clk);

    // R9 / R10: grant, coincident session_end with match, plain session_end
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    check("R9 granted", int'(access_granted), 1);
    check("R9 count zero", int'(fail_count), 0);
    step(1, 1, 1, 0);
    check("R10 match wins over session_end", int'(access_granted), 1);
    step(0, 0, 0, 0);
    check("R10 grant held", int'(access_granted), 1);
    step(0, 0, 1, 0);
    check("R10 session closed", int'(access_granted), 0);

    // R1: reset in the middle of activity keeps storage
    fill_storage();
    step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    check("R1 reset clears count", int'(fail_count), 0);
    check("R1 reset keeps storage", nonzero_words(), D + 2);

    // Random traffic checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      bit d, m, s, r;
      d = ($urandom % 100) < 45;
      m = ($urandom % 100) < 10;
      s = ($urandom % 100) < 6;
      r = ($urandom % 1000) < 3;
      if (!m_busy && !wipe_busy && (i % 500 == 0)) fill_storage();
      step(d, m, s, r);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule